// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a synchronous DRAM read or write burst. A start strobe loads the starting column and the burst configuration. The block then steps through the column sequence, one beat per clock. The configuration is a length code and an ordering flag. The ordering is either sequential, which wraps inside an aligned block of the burst length, or interleaved, which XORs the beat index into the low address bits. A full-page code makes the burst walk the whole 512-column row and wrap around it. A full-page burst only ends when the terminate input is asserted.

A new start is accepted on any clock, including in the middle of a burst, so back-to-back commands lose no beat. The advance enable models clock suspend. It is registered, so freezing and resuming both take effect one clock after the input changes. The outputs are the column address, a valid flag and a last-beat flag. The data path and the rest of the mode register are handled elsewhere.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After synchronous active-low reset, `beat_valid` and `beat_last` are 0 and `col_addr` is 0; `col_addr` reads 0 whenever `beat_valid` is 0.
- R2: Length code 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 beats. Codes 4, 5 and 6 give a single beat. Code 7 selects full page.
- R3: With `ilv_sel`=0 and length N, beat k outputs the starting column with its upper bits unchanged and its low log2(N) bits equal to (start+k) mod N.
- R4: With `ilv_sel`=1 and length N, beat k outputs the starting column XOR k. Under code 7 the `ilv_sel` input has no effect.
- R5: Under code 7, beat k outputs (start+k) mod 512, and the burst continues until terminated.
- R6: `beat_last` is 1 exactly on beat N-1 of a fixed-length burst. It is never 1 during a full-page burst.
- R7: A `burst_go` sampled at a clock edge makes the next cycle beat 0 at the new starting column, even in the middle of a burst. `burst_go` wins over `burst_stop`.
- R8: A `burst_stop` sampled at an edge, with no `burst_go`, clears `beat_valid` from the next cycle.
- R9: `adv_en` is registered. If it is sampled 0 at one edge, the address is held from the following edge onward. Advance resumes at the edge after the edge where it is sampled 1 again.
- R10: Length and ordering are captured at `burst_go`. Later changes on `len_code` or `ilv_sel` do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_go | input | 1 | Start strobe for a new burst |
| start_col | input | 9 | Starting column of the burst |
| len_code | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, 4-6:1) |
| ilv_sel | input | 1 | 1 selects interleaved ordering |
| burst_stop | input | 1 | Terminates the running burst |
| adv_en | input | 1 | Advance enable; 0 suspends advance one clock later |
| col_addr | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is being presented |
| beat_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The hardest case to reach is a full-page wrap from column 511 to 0 that meets a suspend near the wrap point. It is also hard to reach a mid-burst restart during a suspend. Starting at a random column, a full-page burst needs hundreds of beats to reach the wrap. The directed part therefore starts a full page at column 510 and toggles the advance enable around the wrap. The random part favours start columns near the top of the row and keeps the suspend and restart rates high enough that they coincide often.

// File: rtl/colgen_pkg.sv
// Package: shared constants and types for the burst column generator.
// Assumes a 3-bit length code with the full-page code at value 7.
package colgen_pkg;
    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] FULL_PAGE_CODE = 3'd7;

    // Address ordering captured when a burst starts.
    typedef enum logic [1:0] {
        ORD_SEQ  = 2'd0,
        ORD_ILV  = 2'd1,
        ORD_PAGE = 2'd2
    } order_e;
endpackage

// File: rtl/colgen_seq.sv
// Module: burst sequencer. Captures the start column and configuration,
// counts beats, applies terminate and the registered suspend, and flags the
// last beat. Assumes burst_go has priority over burst_stop.
module colgen_seq
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [LEN_CODE_W-1:0] len_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    input  logic                  adv_i,
    output logic                  valid_o,
    output logic                  last_o,
    output logic [COL_W-1:0]      beat_o,
    output logic [COL_W-1:0]      base_o,
    output logic [COL_W-1:0]      mask_o,
    output order_e                order_o
);
    logic             adv_q;
    logic             valid_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    order_e           order_q;
    logic [COL_W-1:0] mask_d;
    order_e           order_d;

    // Decode the length code into a wrap mask and pick the ordering.
    always_comb begin
        case (len_i)
            3'd1:           mask_d = COL_W'(1);
            3'd2:           mask_d = COL_W'(3);
            3'd3:           mask_d = COL_W'(7);
            FULL_PAGE_CODE: mask_d = '1;
            default:        mask_d = '0;
        endcase
        if (len_i == FULL_PAGE_CODE) order_d = ORD_PAGE;
        else if (ilv_i)              order_d = ORD_ILV;
        else                         order_d = ORD_SEQ;
    end

    // Last beat of a fixed-length burst.
    assign last_o = valid_q && (order_q != ORD_PAGE) && (beat_q == mask_q);

    // Register the advance enable to give suspend its one-clock delay.
    always_ff @(posedge clk) begin
        if (!rst_n) adv_q <= 1'b1;
        else        adv_q <= adv_i;
    end

    // Burst state: load on start, clear on stop or final beat, else count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            order_q <= ORD_SEQ;
        end else if (go_i) begin
            valid_q <= 1'b1;
            beat_q  <= '0;
            base_q  <= col_i;
            mask_q  <= mask_d;
            order_q <= order_d;
        end else if (stop_i) begin
            valid_q <= 1'b0;
        end else if (valid_q && adv_q) begin
            if (last_o) valid_q <= 1'b0;
            else        beat_q  <= beat_q + 1'b1;
        end
    end

    assign valid_o = valid_q;
    assign beat_o  = beat_q;
    assign base_o  = base_q;
    assign mask_o  = mask_q;
    assign order_o = order_q;

    // R7: a start always yields beat 0 in the next cycle.
    assert_start_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> (valid_q && beat_q == '0));

    // R9: a held suspend keeps the beat counter still.
    assert_hold_on_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !adv_q && !go_i && !stop_i) |=> $stable(beat_q));

    // R6: advancing past the last beat ends the burst.
    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_q && !go_i && !stop_i) |=> !valid_q);

    // R8: stop without start clears valid.
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !go_i) |=> !valid_q);
endmodule

// File: rtl/colgen_addr.sv
// Module: address former. Combines the captured base column with the beat
// index per the ordering: wrap-within-block add, XOR, or full-row add.
// Assumes mask is 2^m-1 (all ones for full page).
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] addr;

    // Form the beat address and blank it outside a burst.
    always_comb begin
        sum = base_i + beat_i;
        if (order_i == ORD_ILV) addr = base_i ^ (beat_i & mask_i);
        else                    addr = (base_i & ~mask_i) | (sum & mask_i);
        col_o = valid_i ? addr : '0;
    end

    // R3: outside the wrap field the address never leaves the start block.
    assert_block_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> ((col_o & ~mask_i) == (base_i & ~mask_i)));

    // R1: idle output is zero.
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (col_o == '0));
endmodule

// File: rtl/sdr_burst_colgen.sv
// Module: top of the burst column address generator. Wires the sequencer
// to the address former. Assumes one command per clock at most.
module sdr_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  burst_go,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  ilv_sel,
    input  logic                  burst_stop,
    input  logic                  adv_en,
    output logic [COL_W-1:0]      col_addr,
    output logic                  beat_valid,
    output logic                  beat_last
);
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    order_e           order;

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(burst_go), .col_i(start_col),
        .len_i(len_code), .ilv_i(ilv_sel), .stop_i(burst_stop), .adv_i(adv_en),
        .valid_o(beat_valid), .last_o(beat_last), .beat_o(beat),
        .base_o(base), .mask_o(mask), .order_o(order)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .valid_i(beat_valid), .beat_i(beat),
        .base_i(base), .mask_i(mask), .order_i(order), .col_o(col_addr)
    );

    // R6: a full-page burst never raises the last flag.
    assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && order == ORD_PAGE) |-> !beat_last);
endmodule

// File: tb/sdr_burst_colgen_test.sv
module sdr_burst_colgen_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXCYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_go = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ilv_sel = 1'b0;
    logic       burst_stop = 1'b0;
    logic       adv_en = 1'b1;
    logic [8:0] col_addr;
    logic       beat_valid;
    logic       beat_last;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .burst_go(burst_go), .start_col(start_col),
        .len_code(len_code), .ilv_sel(ilv_sel), .burst_stop(burst_stop),
        .adv_en(adv_en), .col_addr(col_addr), .beat_valid(beat_valid),
        .beat_last(beat_last)
    );

    // Reference model, written from the requirements.
    logic       m_valid, m_adv, m_il, m_page;
    logic [8:0] m_beat, m_base;
    int         m_len;

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic logic [8:0] exp_col();
        logic [8:0] n;
        if (!m_valid) return 9'd0;
        n = 9'(m_len - 1);
        if (m_page) return m_base + m_beat;
        if (m_il)   return m_base ^ m_beat;
        return (m_base & ~n) | ((m_base + m_beat) & n);
    endfunction

    function automatic logic exp_last();
        return m_valid && !m_page && (int'(m_beat) == m_len - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_adv <= 1; m_beat <= 0; m_base <= 0;
            m_len <= 1; m_il <= 0; m_page <= 0;
        end else begin
            m_adv <= adv_en;
            if (burst_go) begin
                m_valid <= 1; m_beat <= 0; m_base <= start_col;
                m_len <= len_of(len_code); m_page <= (len_code == 3'd7);
                m_il <= ilv_sel && (len_code != 3'd7);
            end else if (burst_stop) begin
                m_valid <= 0;
            end else if (m_valid && m_adv) begin
                if (exp_last()) m_valid <= 0;
                else            m_beat <= m_beat + 1;
            end
        end
    end

    task automatic check(input string req);
        compared++;
        if (beat_valid !== m_valid || col_addr !== exp_col() || beat_last !== exp_last()) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b col=%0d last=%0b, expected valid=%0b col=%0d last=%0b",
                     req, beat_valid, col_addr, beat_last, m_valid, exp_col(), exp_last());
        end
    endtask

    task automatic check_col(input string req, input logic [8:0] want);
        compared++;
        if (col_addr !== want || beat_valid !== 1'b1) begin
            mismatched++;
            $display("FAIL %s: got col=%0d valid=%0b, expected col=%0d valid=1",
                     req, col_addr, beat_valid, want);
        end
    endtask

    // Apply inputs for one clock and check at the following falling edge.
    task automatic step(input string req, input logic g, input logic [8:0] c,
                        input logic [2:0] l, input logic i, input logic s, input logic a);
        burst_go = g; start_col = c; len_code = l; ilv_sel = i; burst_stop = s; adv_en = a;
        @(negedge clk);
        check(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (MAXCYC) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got no end, expected end within %0d cycles", MAXCYC);
        finish_run();
    end

    initial begin
        void'($urandom(32'h00c0_1a5e));
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;

        // R3: sequential length 4 from 5 -> 5,6,7,4
        step("R3", 1, 9'd5, 3'd2, 0, 0, 1); check_col("R3", 9'd5);
        step("R3", 0, 0, 0, 0, 0, 1);       check_col("R3", 9'd6);
        step("R3", 0, 0, 0, 0, 0, 1);       check_col("R3", 9'd7);
        step("R6", 0, 0, 0, 0, 0, 1);       check_col("R3", 9'd4);
        step("R2", 0, 0, 0, 0, 0, 1);

        // R4: interleave length 8 from 5 -> 5,4,7,6,1,0,3,2 ; R10 mid-burst config change
        step("R4", 1, 9'd5, 3'd3, 1, 0, 1); check_col("R4", 9'd5);
        step("R4", 0, 0, 3'd0, 0, 0, 1);    check_col("R4", 9'd4);
        step("R10", 0, 0, 3'd7, 0, 0, 1);   check_col("R10", 9'd7);
        for (int k = 0; k < 6; k++) step("R4", 0, 0, 0, 0, 0, 1);

        // R2: reserved codes give one beat
        step("R2", 1, 9'd100, 3'd5, 0, 0, 1);
        step("R2", 0, 0, 0, 0, 0, 1);

        // R5: full page wrap from 510 with suspend around the wrap (R9)
        step("R5", 1, 9'd510, 3'd7, 1, 0, 1); check_col("R5", 9'd510);
        step("R5", 0, 0, 0, 0, 0, 1);         check_col("R5", 9'd511);
        step("R9", 0, 0, 0, 0, 0, 0);         check_col("R5", 9'd0);
        step("R9", 0, 0, 0, 0, 0, 1);         check_col("R9", 9'd0);
        step("R9", 0, 0, 0, 0, 0, 1);         check_col("R9", 9'd1);
        for (int k = 0; k < 20; k++) step("R5", 0, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 1, 1);

        // R7: restart mid-burst, and start wins over stop
        step("R7", 1, 9'd40, 3'd3, 0, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 1);
        step("R7", 1, 9'd300, 3'd1, 0, 1, 1); check_col("R7", 9'd300);
        step("R6", 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 0, 1);
        step("R2", 0, 0, 0, 0, 0, 1);

        // Random mix
        for (int n = 0; n < 20000; n++) begin
            logic [8:0] c;
            c = ($urandom % 4 == 0) ? 9'(500 + $urandom % 12) : 9'($urandom);
            step("R2-random", ($urandom % 6) == 0, c, 3'($urandom), 1'($urandom),
                 ($urandom % 25) == 0, ($urandom % 5) != 0);
        end
        finish_run();
    end
endmodule